// File: doc/BRIEF.md
# Paged Monochrome Framebuffer Packer

This block holds a 128 by 64 monochrome image and turns it into the byte stream that a passive-matrix display controller loads into its own RAM. A producer writes one pixel at a time by giving an x coordinate, a y coordinate and a value bit. When a frame is complete, a single flush request streams the whole image out, page by page, as a sequence of command bytes and data bytes on a valid/ready byte stream with a data-or-command flag.

Inside, the image is kept in the same shape the controller uses: eight pages of eight rows each, with every column of a page stored as one byte whose least significant bit is the top row of that page. Columns and rows can each be mirrored at flush time, so a panel mounted rotated or flipped needs no change in the producer. The visible 128 columns can be placed anywhere inside a 132-column controller memory through a column offset parameter. The electrical bus to the controller is not part of this block; a separate bus engine consumes the byte stream.

Top module: `mono_page_packer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0, `pix_ready` is 1 and `done` is 0.
- R2: A pixel write is taken in a cycle where `pix_valid` and `pix_ready` are both 1; the pixel at (`pix_x`, `pix_y`) then holds `pix_value`, so a 1 lights it and a 0 clears it, and later flushes show the new value.
- R3: A write with `pix_x` of 128 or more, or `pix_y` of 64 or more, changes no pixel.
- R4: A `flush_req` seen while idle starts a flush of 1048 bytes: for page p from 0 to 7, three command bytes with `out_is_data` = 0, namely 0xB0+p, then 0x00 plus the low nibble of `COL_OFFSET`, then 0x10 plus the high nibble of `COL_OFFSET`, followed by 128 data bytes with `out_is_data` = 1 for columns 0 to 127 in order.
- R5: With no mirroring, bit b (bit 0 = least significant) of the data byte for page p and column c equals the pixel at x = c, y = 8p+b.
- R6: If `mirror_x` is 1 when the flush starts, the data byte for column c carries the pixels of x = 127-c.
- R7: If `mirror_y` is 1 when the flush starts, output row r = 8p+b carries the pixels of y = 63-r; both mirrors may be set together.
- R8: During a flush `pix_ready` is 0, so a pixel write offered then changes nothing, and a further `flush_req` is ignored.
- R9: While `out_valid` is 1 and `out_ready` is 0, the byte and its flag stay unchanged in the next cycle and `out_valid` stays 1.
- R10: `done` is 1 for exactly one cycle, the cycle after the last data byte of page 7 is accepted; in that cycle `out_valid` is 0 and `pix_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_valid | input | 1 | Pixel write offered |
| pix_ready | output | 1 | Pixel writes accepted (idle) |
| pix_x | input | 8 | Pixel column, 0 to 127 in range |
| pix_y | input | 7 | Pixel row, 0 to 63 in range |
| pix_value | input | 1 | Pixel value, 1 lit |
| flush_req | input | 1 | Start streaming the frame |
| mirror_x | input | 1 | Mirror columns, sampled at flush start |
| mirror_y | input | 1 | Mirror rows, sampled at flush start |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Command or data byte |
| out_is_data | output | 1 | 1 for display data, 0 for a command |
| done | output | 1 | One-cycle pulse at the end of a flush |

## Verification
The bench builds the block at the full 128 by 64 size with a column offset of 18, so both column address commands carry non-zero nibbles (0x02 and 0x11) and a swapped or dropped nibble shows in every page. Keeping the full size means the last column, the last page and the out-of-range coordinates 128 and 64 are all reached, along with every mirror combination against a shadow image. Backpressure from a ready pattern that stalls one cycle in three makes the hold behaviour and the end-of-flush pulse land on stalled and unstalled bytes alike.

// File: rtl/mpp_pkg.sv
// Shared constants and helpers for the paged monochrome packer.
// Assumes the controller command encoding: page select 0xB0+page,
// column low nibble 0x00+n, column high nibble 0x10+n.
package mpp_pkg;

    localparam int PAGE_ROWS = 8;

    localparam logic [7:0] CMD_PAGE_BASE = 8'hB0;
    localparam logic [7:0] CMD_COL_LO    = 8'h00;
    localparam logic [7:0] CMD_COL_HI    = 8'h10;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PAGE  = 3'd1,
        PH_COLLO = 3'd2,
        PH_COLHI = 3'd3,
        PH_DATA  = 3'd4
    } phase_t;

    // Reverse the bit order of a byte (used for row mirroring).
    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = b[7-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/mpp_coord_filter.sv
// Range check and address split for pixel writes.
// Assumes COLS and ROWS are powers of two and ROWS is a multiple of 8.
module mpp_coord_filter #(
    parameter int COLS = 128,
    parameter int ROWS = 64,
    localparam int CW = $clog2(COLS),
    localparam int PW = $clog2(ROWS / 8),
    localparam int XW = CW + 1,
    localparam int YW = $clog2(ROWS) + 1
) (
    input  logic          pix_valid,
    input  logic          pix_ready,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    output logic          wr_en,
    output logic [PW-1:0] wr_page,
    output logic [CW-1:0] wr_col,
    output logic [2:0]    wr_bit
);

    logic in_range;

    // Accept only coordinates inside the visible frame.
    always_comb begin
        in_range = (pix_x < XW'(COLS)) && (pix_y < YW'(ROWS));
        wr_en    = pix_valid && pix_ready && in_range;
        wr_col   = pix_x[CW-1:0];
        wr_page  = pix_y[YW-2:3];
        wr_bit   = pix_y[2:0];
    end

endmodule

// File: rtl/mpp_page_store.sv
// Page-organised frame store: one byte per column per page, bit 0 is the
// top row of the page. Single-bit writes, asynchronous byte read.
// Assumes writes and reads never target the same byte in one cycle
// (the top blocks writes during a flush). Contents are not reset.
module mpp_page_store #(
    parameter int COLS  = 128,
    parameter int PAGES = 8,
    localparam int CW    = $clog2(COLS),
    localparam int PW    = $clog2(PAGES),
    localparam int DEPTH = PAGES * COLS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_page,
    input  logic [CW-1:0] wr_col,
    input  logic [2:0]    wr_bit,
    input  logic          wr_val,
    input  logic [PW-1:0] rd_page,
    input  logic [CW-1:0] rd_col,
    output logic [7:0]    rd_byte
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    // Linear addresses: page-major, column-minor.
    always_comb begin
        waddr = AW'(wr_page) * AW'(COLS) + AW'(wr_col);
        raddr = AW'(rd_page) * AW'(COLS) + AW'(rd_col);
    end

    // Update a single pixel bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[waddr][wr_bit] <= wr_val;
        end
    end

    // Byte read for the stream.
    assign rd_byte = mem[raddr];

endmodule

// File: rtl/mpp_flush_seq.sv
// Flush sequencer: walks pages 0..PAGES-1, emitting a page command, two
// column address commands and COLS data bytes per page on a valid/ready
// stream. Mirror settings are captured when the flush starts.
// Assumes the store answers a read address in the same cycle.
module mpp_flush_seq
    import mpp_pkg::*;
#(
    parameter int COLS       = 128,
    parameter int PAGES      = 8,
    parameter int COL_OFFSET = 0,
    localparam int CW = $clog2(COLS),
    localparam int PW = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mirror_x,
    input  logic          mirror_y,
    output logic          busy,
    output logic [PW-1:0] rd_page,
    output logic [CW-1:0] rd_col,
    input  logic [7:0]    rd_byte,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_is_data,
    output logic          done
);

    localparam logic [CW-1:0] LAST_COL  = CW'(COLS - 1);
    localparam logic [PW-1:0] LAST_PAGE = PW'(PAGES - 1);
    localparam logic [7:0]    LO_CMD    = CMD_COL_LO | 8'(COL_OFFSET % 16);
    localparam logic [7:0]    HI_CMD    = CMD_COL_HI | 8'(COL_OFFSET / 16);

    phase_t        phase;
    logic [PW-1:0] page_q;
    logic [CW-1:0] col_q;
    logic          mx_q;
    logic          my_q;
    logic          fire;

    assign out_valid = (phase != PH_IDLE);
    assign busy      = out_valid;
    assign fire      = out_valid && out_ready;

    // Map the output position to the stored position under mirroring.
    always_comb begin
        rd_page = my_q ? (LAST_PAGE - page_q) : page_q;
        rd_col  = mx_q ? (LAST_COL - col_q) : col_q;
    end

    // Select the byte and its flag for the current phase.
    always_comb begin
        out_is_data = 1'b0;
        case (phase)
            PH_PAGE:  out_data = CMD_PAGE_BASE | 8'(page_q);
            PH_COLLO: out_data = LO_CMD;
            PH_COLHI: out_data = HI_CMD;
            PH_DATA: begin
                out_data    = my_q ? rev8(rd_byte) : rd_byte;
                out_is_data = 1'b1;
            end
            default:  out_data = 8'h00;
        endcase
    end

    // Phase, page and column counters advance on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            page_q <= '0;
            col_q  <= '0;
            mx_q   <= 1'b0;
            my_q   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_PAGE;
                        page_q <= '0;
                        col_q  <= '0;
                        mx_q   <= mirror_x;
                        my_q   <= mirror_y;
                    end
                end
                PH_PAGE:  if (fire) phase <= PH_COLLO;
                PH_COLLO: if (fire) phase <= PH_COLHI;
                PH_COLHI: if (fire) phase <= PH_DATA;
                PH_DATA: begin
                    if (fire) begin
                        if (col_q == LAST_COL) begin
                            col_q <= '0;
                            if (page_q == LAST_PAGE) begin
                                phase <= PH_IDLE;
                                done  <= 1'b1;
                            end else begin
                                page_q <= page_q + 1'b1;
                                phase  <= PH_PAGE;
                            end
                        end else begin
                            col_q <= col_q + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mono_page_packer.sv
// Top of the paged monochrome framebuffer packer. Pixel writes go to a
// page-organised store while idle; a flush streams the frame as
// controller commands and data bytes. Writes are held off during a flush.
// Assumes COLS and ROWS are powers of two, ROWS a multiple of 8.
module mono_page_packer #(
    parameter int COLS       = 128,
    parameter int ROWS       = 64,
    parameter int COL_OFFSET = 0,
    localparam int PAGES = ROWS / mpp_pkg::PAGE_ROWS,
    localparam int CW    = $clog2(COLS),
    localparam int PW    = $clog2(PAGES),
    localparam int XW    = CW + 1,
    localparam int YW    = $clog2(ROWS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    output logic          pix_ready,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    input  logic          pix_value,
    input  logic          flush_req,
    input  logic          mirror_x,
    input  logic          mirror_y,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_is_data,
    output logic          done
);

    logic          busy;
    logic          wr_en;
    logic [PW-1:0] wr_page;
    logic [CW-1:0] wr_col;
    logic [2:0]    wr_bit;
    logic [PW-1:0] rd_page;
    logic [CW-1:0] rd_col;
    logic [7:0]    rd_byte;

    assign pix_ready = !busy;

    mpp_coord_filter #(.COLS(COLS), .ROWS(ROWS)) u_filter (
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .wr_en     (wr_en),
        .wr_page   (wr_page),
        .wr_col    (wr_col),
        .wr_bit    (wr_bit)
    );

    mpp_page_store #(.COLS(COLS), .PAGES(PAGES)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_page (wr_page),
        .wr_col  (wr_col),
        .wr_bit  (wr_bit),
        .wr_val  (pix_value),
        .rd_page (rd_page),
        .rd_col  (rd_col),
        .rd_byte (rd_byte)
    );

    mpp_flush_seq #(.COLS(COLS), .PAGES(PAGES), .COL_OFFSET(COL_OFFSET)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (flush_req),
        .mirror_x    (mirror_x),
        .mirror_y    (mirror_y),
        .busy        (busy),
        .rd_page     (rd_page),
        .rd_col      (rd_col),
        .rd_byte     (rd_byte),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_is_data (out_is_data),
        .done        (done)
    );

endmodule

// File: rtl/mono_page_packer_chk.sv
// Protocol checker for mono_page_packer, attached by bind.
// Assumes it sees the top-level ports only.
module mono_page_packer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_is_data,
    input logic       done
);

    // R9
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_is_data)));

    // R8
    no_write_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_ready && out_valid));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid && out_ready && out_is_data) && !out_valid && pix_ready));

    // R4
    first_byte_page0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data == 8'hB0 && !out_is_data));

    // R4
    page_then_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_is_data && out_data[7:4] == 4'hB)
        |=> (out_valid && !out_is_data && out_data[7:4] == 4'h0));

endmodule

bind mono_page_packer mono_page_packer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_ready   (pix_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_is_data (out_is_data),
    .done        (done)
);

// File: tb/mono_page_packer_bench.sv
`timescale 1ns/100ps
// Directed bench for mono_page_packer: one task per scenario, a shadow
// image as reference, expected stream computed from the requirements.
module mono_page_packer_bench;

    localparam int OFF   = 18;
    localparam int TOTAL = 8 * 131;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_valid;
    logic       pix_ready;
    logic [7:0] pix_x;
    logic [6:0] pix_y;
    logic       pix_value;
    logic       flush_req;
    logic       mirror_x;
    logic       mirror_y;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;
    logic       out_is_data;
    logic       done;

    int checks   = 0;
    int failures = 0;
    bit model [0:63][0:127];

    always #2 clk = ~clk;

    mono_page_packer #(.COLS(128), .ROWS(64), .COL_OFFSET(OFF)) u_mono_page_packer (
        .clk (clk), .rst_n (rst_n),
        .pix_valid (pix_valid), .pix_ready (pix_ready),
        .pix_x (pix_x), .pix_y (pix_y), .pix_value (pix_value),
        .flush_req (flush_req), .mirror_x (mirror_x), .mirror_y (mirror_y),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_is_data (out_is_data), .done (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected {flag, byte} for stream position idx.
    function automatic logic [8:0] exp_at(int idx, bit mx, bit my);
        int p = idx / 131;
        int k = idx % 131;
        logic [7:0] v;
        if (k == 0) return {1'b0, 8'hB0 + 8'(p)};
        if (k == 1) return {1'b0, 8'(OFF % 16)};
        if (k == 2) return {1'b0, 8'h10 | 8'(OFF / 16)};
        for (int b = 0; b < 8; b++) begin
            int r  = p * 8 + b;
            int lr = my ? 63 - r : r;
            int lc = mx ? 127 - (k - 3) : (k - 3);
            v[b] = model[lr][lc];
        end
        return {1'b1, v};
    endfunction

    task automatic write_px(input int x, input int y, input bit v);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_x = 8'(x);
        pix_y = 7'(y);
        pix_value = v;
        @(negedge clk);
        pix_valid = 1'b0;
        if (x < 128 && y < 64) model[y][x] = v;
    endtask

    task automatic clear_all();
        @(negedge clk);
        pix_valid = 1'b1;
        pix_value = 1'b0;
        for (int y = 0; y < 64; y++) begin
            for (int x = 0; x < 128; x++) begin
                pix_x = 8'(x);
                pix_y = 7'(y);
                model[y][x] = 1'b0;
                @(negedge clk);
            end
        end
        pix_valid = 1'b0;
    endtask

    // Run one flush and compare every byte; optional stalls and intrusions.
    task automatic run_flush(input string req, input bit mx, input bit my,
                             input bit stall, input bit intrude);
        int idx = 0;
        int cyc = 0;
        int bad = 0;
        int bp_bad = 0;
        int early = 0;
        int rdy_bad = 0;
        bit prev_stall = 1'b0;
        logic [8:0] prev = '0;
        logic [8:0] e;
        @(negedge clk);
        mirror_x  = mx;
        mirror_y  = my;
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        mirror_x  = ~mx;
        mirror_y  = ~my;
        while (idx < TOTAL && cyc < 20000) begin
            if (cyc != 0) @(negedge clk);
            out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (intrude) begin
                pix_valid = (idx < 500);
                pix_x = 8'd7; pix_y = 7'd7; pix_value = 1'b1;
                flush_req = (idx == 200);
            end
            cyc++;
            #1;
            if (prev_stall && !(out_valid && {out_is_data, out_data} == prev)) bp_bad++;
            if (done) early++;
            if (pix_ready) rdy_bad++;
            prev_stall = out_valid && !out_ready;
            prev = {out_is_data, out_data};
            if (out_valid && out_ready) begin
                e = exp_at(idx, mx, my);
                if ({out_is_data, out_data} != e) begin
                    if (bad == 0)
                        $display("FAIL %s byte %0d actual=0x%0h expected=0x%0h",
                                 req, idx, {out_is_data, out_data}, e);
                    bad++;
                end
                idx++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        pix_valid = 1'b0;
        flush_req = 1'b0;
        #1;
        checks++;
        if (bad != 0 || idx != TOTAL) begin
            failures++;
            $display("FAIL %s stream mismatches=%0d bytes=%0d expected bytes=%0d", req, bad, idx, TOTAL);
        end
        check(done && !out_valid && pix_ready, "R10 done after last byte",
              {done, out_valid, pix_ready}, 3'b101);
        check(early == 0, "R10 no early done", early, 0);
        check(rdy_bad == 0, "R8 pix_ready low during flush", rdy_bad, 0);
        if (stall) check(bp_bad == 0, "R9 hold under stall", bp_bad, 0);
        @(negedge clk);
        #1;
        check(!done && !out_valid, "R10 done lasts one cycle", {done, out_valid}, 2'b00);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        pix_valid = 1'b0; pix_x = '0; pix_y = '0; pix_value = 1'b0;
        flush_req = 1'b0; mirror_x = 1'b0; mirror_y = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid && pix_ready && !done, "R1 state in reset",
              {out_valid, pix_ready, done}, 3'b010);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid && pix_ready && !done, "R1 state after reset",
              {out_valid, pix_ready, done}, 3'b010);
    endtask

    task automatic t_blank();
        clear_all();
        run_flush("R4 blank frame commands", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_pattern();
        write_px(0, 0, 1'b1);
        write_px(127, 63, 1'b1);
        write_px(5, 9, 1'b1);
        write_px(64, 31, 1'b1);
        write_px(126, 0, 1'b1);
        for (int i = 0; i < 64; i++) write_px(i * 2, i, 1'b1);
        run_flush("R5 R2 pattern", 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_clear_px();
        write_px(5, 9, 1'b0);
        write_px(0, 0, 1'b0);
        run_flush("R2 cleared pixels", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_range();
        write_px(128, 3, 1'b1);
        write_px(200, 10, 1'b1);
        write_px(3, 64, 1'b1);
        write_px(255, 127, 1'b1);
        run_flush("R3 out of range ignored", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_mirrors();
        run_flush("R6 mirror columns", 1'b1, 1'b0, 1'b1, 1'b0);
        run_flush("R7 mirror rows", 1'b0, 1'b1, 1'b0, 1'b0);
        run_flush("R7 R6 both mirrors", 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_holdoff();
        // pixel (7,7) stays 0 in the model: writes offered during the flush must not land
        run_flush("R8 writes held off", 1'b0, 1'b0, 1'b1, 1'b1);
        run_flush("R8 frame unchanged after holdoff", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_blank();
        t_pattern();
        t_clear_px();
        t_range();
        t_mirrors();
        t_holdoff();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule